// File: doc/BRIEF.md
# Register Operand Select and Add Datapath

This block is a small execute stage for register-to-register add instructions. A 32-bit instruction word arrives as four bytes on a byte stream with a valid strobe. The first byte is the least significant, so the byte sequence 08 A0 83 E0 forms the word E083A008. When the word is complete it sits in an instruction register. Three 4-bit fields of that word then choose two source registers and a destination register in a 16-entry register file.

Each ALU input has its own bank of multiplexers. The bank has one N-to-1 multiplexer per data bit, and every slice in a bank shares the same select. The two banks are the same circuit and differ only in which field drives their select. The adder sums the two selected values, and the sum is written back to the destination register. The sum is also shown on the result port, together with a one-cycle done pulse.

A side port lets a test environment load and inspect any register while no instruction is in flight.

Top module: `opadd_datapath`

## Requirements
- R1: Bytes accepted on byte_i while byte_valid_i is high are packed least significant first: the k-th accepted byte of a word (k = 0..3) lands in word bits 8k+7:8k, so bytes 08, A0, 83, E0 form E083A008.
- R2: Word bits 19:16 hold the left source register number n. Every bit of register n is routed to the left adder input.
- R3: Word bits 3:0 hold the right source register number m. Every bit of register m is routed to the right adder input through an identical bank of multiplexers.
- R4: The sum of register n and register m, taken modulo 2^DATA_W with no carry kept, is written to the register numbered by word bits 15:12. Example: E083A008, E084A007 and E089A005 compute r10 = r3+r8, r10 = r4+r7 and r10 = r9+r5.
- R5: The fourth byte is captured on some clock edge. On the next edge the register write happens, done_o goes high for exactly one cycle, and result_o takes the sum. result_o then holds that value until the next done pulse.
- R6: If byte_valid_i is high in the cycle between the fourth byte and the write-back, the byte is ignored. The next word starts from byte 0.
- R7: When a source register is also the destination, the value read is the one held before the write.
- R8: sb_rdata_o always shows register sb_addr_i, combinationally. sb_we_i writes sb_wdata_i to register sb_addr_i only when the block is idle, meaning no partial word has been received and no write-back is pending. At any other time sb_we_i is ignored.
- R9: An active-low asynchronous reset clears every register, the instruction register, the byte count, result_o and done_o to zero.
- R10: Word bits 31:20 and 11:4 have no effect on the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Instruction byte |
| byte_valid_i | input | 1 | byte_i carries a valid byte this cycle |
| sb_we_i | input | 1 | Side-port write enable (honoured only while idle) |
| sb_addr_i | input | 4 | Side-port register number |
| sb_wdata_i | input | DATA_W | Side-port write data |
| sb_rdata_o | output | DATA_W | Contents of register sb_addr_i |
| result_o | output | DATA_W | Sum of the last completed instruction |
| done_o | output | 1 | One-cycle pulse marking a write-back |

## Verification
The bench runs every combination of left source, right source and destination register, 4096 words in all. The filler bits vary from word to word, and the bench reads back the destination after each write. A design with swapped or shifted fields, or with byte order reversed, gives wrong sums. A design with a bit slice tied to the wrong select corrupts only some bits of the result. A design that reads after the write shows wrong values whenever a source equals the destination. The bench also sends a stray byte during the write-back cycle and a side-port write in the middle of a word. A design that accepts either of these misdecodes the following word or overwrites a register that should have kept its value.

// File: rtl/opadd_pkg.sv
package opadd_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NBYTES   = INSTR_W / BYTE_W;
  localparam int unsigned CNT_W    = $clog2(NBYTES);
  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned SRC_A_LSB = 16;
  localparam int unsigned DST_LSB   = 12;
  localparam int unsigned SRC_B_LSB = 0;

  typedef struct packed {
    logic [FIELD_W-1:0] src_a;
    logic [FIELD_W-1:0] src_b;
    logic [FIELD_W-1:0] dst;
  } reg_fields_t;

  function automatic reg_fields_t decode_fields(input logic [INSTR_W-1:0] w);
    reg_fields_t f;
    f.src_a = w[SRC_A_LSB +: FIELD_W];
    f.src_b = w[SRC_B_LSB +: FIELD_W];
    f.dst   = w[DST_LSB   +: FIELD_W];
    return f;
  endfunction
endpackage

// File: rtl/opadd_ir_assembler.sv
module opadd_ir_assembler
  import opadd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               byte_valid_i,
  output logic [INSTR_W-1:0] ir_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               exec_o
);
  logic [INSTR_W-1:0] ir_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               exec_q;
  logic               accept;

  // bytes are dropped during the write-back cycle
  assign accept = byte_valid_i && !exec_q;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ir_q[k*BYTE_W +: BYTE_W] <= '0;
      end else if (accept && cnt_q == CNT_W'(k)) begin
        ir_q[k*BYTE_W +: BYTE_W] <= byte_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      exec_q <= 1'b0;
    end else begin
      if (accept) cnt_q <= cnt_q + 1'b1;
      exec_q <= accept && (cnt_q == CNT_W'(NBYTES - 1));
    end
  end

  assign ir_o   = ir_q;
  assign cnt_o  = cnt_q;
  assign exec_o = exec_q;
endmodule

// File: rtl/opadd_regfile.sv
module opadd_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 16,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (we_i && waddr_i == AW'(r)) begin
        q <= wdata_i;
      end
    end
    assign regs_o[r*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/opadd_operand_sel.sv
module opadd_operand_sel #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 16,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic [NREG*DATA_W-1:0] regs_i,
  input  logic [AW-1:0]          sel_i,
  output logic [DATA_W-1:0]      operand_o
);
  // one NREG:1 mux per data bit, all sharing sel_i
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [NREG-1:0] slice;
    for (genvar r = 0; r < NREG; r++) begin : g_src
      assign slice[r] = regs_i[r*DATA_W + b];
    end
    assign operand_o[b] = slice[sel_i];
  end
endmodule

// File: rtl/opadd_datapath.sv
module opadd_datapath
  import opadd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 16,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  input  logic              sb_we_i,
  input  logic [3:0]        sb_addr_i,
  input  logic [DATA_W-1:0] sb_wdata_i,
  output logic [DATA_W-1:0] sb_rdata_o,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  logic [INSTR_W-1:0]     ir;
  logic [CNT_W-1:0]       cnt;
  logic                   exec;
  reg_fields_t            fld;
  logic [NREG*DATA_W-1:0] regs;
  logic [DATA_W-1:0]      op_a, op_b, sum;
  logic                   idle;
  logic                   rf_we;
  logic [AW-1:0]          rf_waddr;
  logic [DATA_W-1:0]      rf_wdata;
  logic [DATA_W-1:0]      result_q;
  logic                   done_q;

  opadd_ir_assembler u_ir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_i       (byte_i),
    .byte_valid_i (byte_valid_i),
    .ir_o         (ir),
    .cnt_o        (cnt),
    .exec_o       (exec)
  );

  assign fld = decode_fields(ir);

  opadd_operand_sel #(.DATA_W(DATA_W), .NREG(NREG)) u_sel_a (
    .regs_i    (regs),
    .sel_i     (AW'(fld.src_a)),
    .operand_o (op_a)
  );

  opadd_operand_sel #(.DATA_W(DATA_W), .NREG(NREG)) u_sel_b (
    .regs_i    (regs),
    .sel_i     (AW'(fld.src_b)),
    .operand_o (op_b)
  );

  assign sum  = op_a + op_b;
  assign idle = (cnt == '0) && !exec;

  always_comb begin
    if (exec) begin
      rf_we    = 1'b1;
      rf_waddr = AW'(fld.dst);
      rf_wdata = sum;
    end else begin
      rf_we    = sb_we_i && idle;
      rf_waddr = AW'(sb_addr_i);
      rf_wdata = sb_wdata_i;
    end
  end

  opadd_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .regs_o  (regs)
  );

  opadd_operand_sel #(.DATA_W(DATA_W), .NREG(NREG)) u_sel_sb (
    .regs_i    (regs),
    .sel_i     (AW'(sb_addr_i)),
    .operand_o (sb_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= exec;
      if (exec) result_q <= sum;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/opadd_datapath_sva.sv
module opadd_datapath_sva #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic [1:0]        cnt,
  input logic              exec,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o
);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_after_fourth_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(byte_valid_i && cnt == 2'd3 && !exec, 2));

  a_r4_result_is_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o == DATA_W'($past(op_a) + $past(op_b)));

  a_r6_count_clear_on_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec |-> cnt == 2'd0);

  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) || $past(!rst_ni));
endmodule

bind opadd_datapath opadd_datapath_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .cnt          (cnt),
  .exec         (exec),
  .op_a         (op_a),
  .op_b         (op_b),
  .result_o     (result_o),
  .done_o       (done_o)
);

// File: tb/opadd_datapath_tb.sv
`timescale 1ns/1ps
module opadd_datapath_tb;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   byte_i = '0;
  logic         byte_valid_i = 1'b0;
  logic         sb_we_i = 1'b0;
  logic [3:0]   sb_addr_i = '0;
  logic [W-1:0] sb_wdata_i = '0;
  logic [W-1:0] sb_rdata_o, result_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [16];

  always #10 clk_i = ~clk_i;

  opadd_datapath #(.DATA_W(W), .NREG(16)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic sb_write(input int r, input logic [W-1:0] v);
    @(negedge clk_i);
    sb_we_i = 1'b1; sb_addr_i = 4'(r); sb_wdata_i = v;
    @(negedge clk_i);
    sb_we_i = 1'b0;
  endtask

  task automatic send_bytes(input logic [31:0] w, input int first, input int last);
    for (int k = first; k <= last; k++) begin
      @(negedge clk_i);
      byte_valid_i = 1'b1; byte_i = w[8*k +: 8];
    end
  endtask

  // finish a word whose last byte was just driven; check timing, result, writeback
  task automatic complete(input logic [31:0] w, input bit stray, input string req);
    int n, m, d;
    logic [W-1:0] exp;
    n = int'(w[19:16]); m = int'(w[3:0]); d = int'(w[15:12]);
    exp = model[n] + model[m];
    @(negedge clk_i);
    byte_valid_i = stray; byte_i = 8'hFF;
    chk("R5 done low in capture cycle", {31'd0, done_o}, 32'd0);
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    chk("R5 done pulse", {31'd0, done_o}, 32'd1);
    chk(req, {24'd0, result_o}, {24'd0, exp});
    model[d] = exp;
    sb_addr_i = 4'(d);
    #1;
    chk("R4 destination writeback", {24'd0, sb_rdata_o}, {24'd0, exp});
    @(negedge clk_i);
    chk("R5 done single cycle", {31'd0, done_o}, 32'd0);
    chk("R5 result holds", {24'd0, result_o}, {24'd0, exp});
  endtask

  task automatic run_word(input logic [31:0] w, input string req);
    send_bytes(w, 0, 3);
    complete(w, 1'b0, req);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '0;
    #35;
    // R9 reset state
    chk("R9 done after reset", {31'd0, done_o}, 32'd0);
    chk("R9 result after reset", {24'd0, result_o}, 32'd0);
    rst_ni = 1'b1;
    for (int r = 0; r < 16; r++) begin
      @(negedge clk_i);
      sb_addr_i = 4'(r); #1;
      chk("R9 register cleared", {24'd0, sb_rdata_o}, 32'd0);
    end

    // R8 idle side-port writes
    for (int r = 0; r < 16; r++) begin
      model[r] = W'(r * 37 + 11);
      sb_write(r, model[r]);
    end
    for (int r = 0; r < 16; r++) begin
      @(negedge clk_i);
      sb_addr_i = 4'(r); #1;
      chk("R8 side-port readback", {24'd0, sb_rdata_o}, {24'd0, model[r]});
    end

    // R1/R4 example words
    run_word(32'hE083A008, "R1 R4 r10=r3+r8");
    run_word(32'hE084A007, "R1 R4 r10=r4+r7");
    run_word(32'hE089A005, "R1 R4 r10=r9+r5");

    // R6 stray byte during write-back cycle
    send_bytes(32'hE0812003, 0, 3);
    complete(32'hE0812003, 1'b1, "R6 word before stray byte");
    run_word(32'hE0823004, "R6 next word decodes from byte 0");

    // R8 side-port write in mid-word is ignored
    send_bytes(32'hE0861007, 0, 1);
    @(negedge clk_i);
    byte_valid_i = 1'b0; sb_we_i = 1'b1; sb_addr_i = 4'd5; sb_wdata_i = ~model[5];
    @(negedge clk_i);
    sb_we_i = 1'b0;
    send_bytes(32'hE0861007, 2, 3);
    complete(32'hE0861007, 1'b0, "R8 word around blocked write");
    sb_addr_i = 4'd5; #1;
    chk("R8 busy write ignored", {24'd0, sb_rdata_o}, {24'd0, model[5]});

    // R2 R3 R4 R7 R10 full sweep of fields, varied filler bits
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] w;
      logic [11:0] hi;
      logic [7:0]  mid;
      hi  = 12'(i * 2654435 + 7);
      mid = 8'(i * 73 + 5);
      w = {hi, 4'(i >> 8), 4'(i >> 4), mid, 4'(i)};
      if (w[19:16] == w[15:12] || w[3:0] == w[15:12])
        run_word(w, "R7 R10 read before write");
      else
        run_word(w, "R2 R3 R4 R10 sweep");
    end

    finish_run();
  end
endmodule